// File: doc/BRIEF.md
# Framed Word Serializer

This block turns a stream of parallel words into a single serial bit line. Every period of a slow word clock it emits one frame made of a high marker bit, the data bits of the word (least significant first) and a low marker bit. The guaranteed high-to-low change inside every frame gives a downstream receiver an edge to recover timing from. The block runs entirely on a fast bit clock that is phase-aligned to the word clock at exactly twelve times its rate (for the default ten-bit word). The word clock reaches the block as a level input sampled on the bit clock. The design detects its edges there and uses them both to capture the parallel word and to mark frame boundaries.

The host picks which word-clock edge captures the parallel input. A captured word waits in a holding register and moves into the shift register only at the next frame boundary. A frame already on the wire is therefore never changed by a new capture. To let a receiver acquire lock quickly, the host can request a fixed alignment frame: six ones followed by six zeros. Once the request has been seen at enough consecutive boundaries, a burst of a guaranteed minimum length starts and carries on for as long as the request stays high.

After reset or a power-down, the block waits a set number of word periods before it captures words or drives its output. That wait stands in for the settling time of an external clock multiplier. The output-enable pin is meant for an external tri-state line driver. It follows the enable and power-down pins without waiting for a clock edge, and it does not disturb frame timing.

Top module: `wser_top`

## Requirements
- R1: Each frame is DATA_W+2 bits long. The first bit sent is a 1 (start marker) and the last bit sent is a 0 (stop marker), so each frame has at least one 1-to-0 transition.
- R2: The data bits follow the start marker, bit 0 first and bit DATA_W-1 last. A new frame begins on the bit-clock cycle after each rising edge of the word clock is sampled, so one frame is sent per word period.
- R3: With edge_sel=1 the word on din is captured at the sampled rising edge of the word clock. With edge_sel=0 it is captured at the sampled falling edge.
- R4: A captured word is sent in the frame that begins at the next rising edge after the capture. A word on din at a time that is not a selected capture edge never appears in any frame.
- R5: An alignment frame sends ones in its first six bit slots and zeros in its last six (12'h03F, bit 0 sent first). din has no effect on it. The choice between data and alignment frames is made only at a frame boundary, so sync_req changing in the middle of a frame never produces a mixed frame.
- R6: An alignment burst starts only when sync_req is 1 at SYNC_QUAL consecutive frame boundaries. The first alignment frame is the one that begins at the SYNC_QUAL-th of those boundaries. A run shorter than that leaves every frame as data.
- R7: Once started, a burst sends at least SYNC_MIN alignment frames, whatever sync_req does during them.
- R8: While sync_req stays 1, alignment frames continue past SYNC_MIN. The first frame boundary that sees sync_req at 0 after the burst length has been reached sends data again.
- R9: sout_oe is 1 only while en=1, pwrdn=0 and the block is locked. It follows en and pwrdn with no clock edge. en does not change frame timing.
- R10: After reset or after pwrdn is released, the block counts LOCK_FRAMES rising edges of the word clock. Until then it does not capture, does not start frames, and keeps sout_oe at 0.
- R11: Until the first capture after locking, frames carry all-zero data with normal start and stop markers.
- R12: pwrdn=1 clears the lock, the holding register, the alignment state and the frame in progress, and forces sout to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, twelve times the word clock rate and phase-aligned to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Word clock level, sampled on clk |
| edge_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| din | input | DATA_W | Parallel word |
| sync_req | input | 1 | Request for alignment frames |
| en | input | 1 | Output enable request |
| pwrdn | input | 1 | Power-down, active high |
| sout | output | 1 | Serial bit stream |
| sout_oe | output | 1 | Drive enable for the external line driver |

## Verification
The interesting overlaps are a capture and a frame load landing on the same sampled rising edge, and an alignment request changing while a data frame is being shifted. The bench drives a new word exactly on the rising edge. It checks that the frame starting there carries the previously held word and that the new word appears one frame later. It also flips sync_req in the middle of frames and during bursts, and compares every bit of every frame against a frame-level model that decides the frame type only at boundaries. Enable is also dropped and raised in the middle of frames, and the output-enable pin is judged without waiting for a clock edge while the frame contents keep being compared.

// File: rtl/wser_pkg.sv
package wser_pkg;

    // Frame content selected at each frame boundary
    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_SYNC = 1'b1
    } frame_mode_e;

endpackage

// File: rtl/wser_edge.sv
// Word-clock edge detection and parallel word capture.
module wser_edge #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              edge_sel,
    input  logic              active,
    input  logic              clear,
    input  logic [DATA_W-1:0] din,
    output logic              rise,
    output logic              cap,
    output logic [DATA_W-1:0] hold
);

    typedef struct packed {
        logic              prev;
        logic [DATA_W-1:0] word;
    } edge_st_t;

    edge_st_t s_d, s_q;
    logic     fall;

    always_comb begin
        s_d  = s_q;
        rise = ref_clk & ~s_q.prev;
        fall = ~ref_clk & s_q.prev;
        cap  = active & (edge_sel ? rise : fall);
        s_d.prev = ref_clk;
        if (clear) begin
            s_d.word = '0;
        end else if (cap) begin
            s_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold = s_q.word;

endmodule

// File: rtl/wser_ctrl.sv
// Lock wait, alignment-request qualification, burst length and frame decision.
module wser_ctrl
    import wser_pkg::*;
#(
    parameter int LOCK_FRAMES = 2048,
    parameter int SYNC_QUAL   = 6,
    parameter int SYNC_MIN    = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwrdn,
    input  logic        rise,
    input  logic        sync_req,
    output logic        locked,
    output logic        load,
    output frame_mode_e mode,
    output logic        burst_act
);

    localparam int LCW = $clog2(LOCK_FRAMES + 1);
    localparam int QW  = $clog2(SYNC_QUAL + 1);
    localparam int BW  = $clog2(SYNC_MIN + 1);

    localparam logic [LCW-1:0] LOCK_LAST = LCW'(LOCK_FRAMES - 1);
    localparam logic [QW-1:0]  QUAL_MAX  = QW'(SYNC_QUAL);
    localparam logic [BW-1:0]  BURST_RLD = BW'(SYNC_MIN - 1);

    typedef struct packed {
        logic [LCW-1:0] lock_cnt;
        logic           locked;
        logic [QW-1:0]  qual;
        logic [BW-1:0]  burst;
    } ctrl_st_t;

    ctrl_st_t       s_d, s_q;
    logic [QW-1:0]  qual_nx;

    always_comb begin
        s_d     = s_q;
        load    = 1'b0;
        mode    = MODE_DATA;
        qual_nx = '0;
        if (pwrdn) begin
            s_d = '0;
        end else if (!s_q.locked) begin
            if (rise) begin
                if (s_q.lock_cnt == LOCK_LAST) begin
                    s_d.locked   = 1'b1;
                    s_d.lock_cnt = '0;
                end else begin
                    s_d.lock_cnt = s_q.lock_cnt + 1'b1;
                end
            end
        end else if (rise) begin
            load = 1'b1;
            if (sync_req) begin
                qual_nx = (s_q.qual == QUAL_MAX) ? s_q.qual : s_q.qual + 1'b1;
            end
            s_d.qual = qual_nx;
            if (s_q.burst != '0) begin
                mode      = MODE_SYNC;
                s_d.burst = s_q.burst - 1'b1;
            end else if (qual_nx == QUAL_MAX) begin
                mode      = MODE_SYNC;
                s_d.burst = BURST_RLD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign locked    = s_q.locked;
    assign burst_act = (s_q.burst != '0);

endmodule

// File: rtl/wser_shift.sv
// Frame builder and shift register; serial output is the register LSB.
module wser_shift
    import wser_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn,
    input  logic              load,
    input  frame_mode_e       mode,
    input  logic [DATA_W-1:0] word,
    output logic              sout
);

    localparam int FRAME_W = DATA_W + 2;

    function automatic logic [FRAME_W-1:0] make_sync();
        logic [FRAME_W-1:0] r;
        for (int i = 0; i < FRAME_W; i++) begin
            r[i] = (i < FRAME_W / 2);
        end
        return r;
    endfunction

    localparam logic [FRAME_W-1:0] SYNC_PAT = make_sync();

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } shift_st_t;

    shift_st_t          s_d, s_q;
    logic [FRAME_W-1:0] data_frame;

    // start marker at bit 0, data LSB first, stop marker last
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_map
            assign data_frame[g+1] = word[g];
        end
    endgenerate
    assign data_frame[0]         = 1'b1;
    assign data_frame[FRAME_W-1] = 1'b0;

    always_comb begin
        s_d = s_q;
        if (pwrdn) begin
            s_d.frame = '0;
        end else if (load) begin
            s_d.frame = (mode == MODE_SYNC) ? SYNC_PAT : data_frame;
        end else begin
            s_d.frame = {1'b0, s_q.frame[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sout = s_q.frame[0];

endmodule

// File: rtl/wser_top.sv
module wser_top
    import wser_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LOCK_FRAMES = 2048,
    parameter int SYNC_QUAL   = 6,
    parameter int SYNC_MIN    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              edge_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              sync_req,
    input  logic              en,
    input  logic              pwrdn,
    output logic              sout,
    output logic              sout_oe
);

    logic              frame_rise;
    logic              cap_strobe;
    logic [DATA_W-1:0] hold_word;
    logic              locked;
    logic              frame_load;
    frame_mode_e       frame_mode;
    logic              burst_act;
    logic              frame_is_sync;
    logic              run_ok;

    assign run_ok        = locked & ~pwrdn;
    assign frame_is_sync = (frame_mode == MODE_SYNC);

    wser_edge #(.DATA_W(DATA_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .edge_sel (edge_sel),
        .active   (run_ok),
        .clear    (pwrdn),
        .din      (din),
        .rise     (frame_rise),
        .cap      (cap_strobe),
        .hold     (hold_word)
    );

    wser_ctrl #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .SYNC_QUAL   (SYNC_QUAL),
        .SYNC_MIN    (SYNC_MIN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrdn     (pwrdn),
        .rise      (frame_rise),
        .sync_req  (sync_req),
        .locked    (locked),
        .load      (frame_load),
        .mode      (frame_mode),
        .burst_act (burst_act)
    );

    wser_shift #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .pwrdn (pwrdn),
        .load  (frame_load),
        .mode  (frame_mode),
        .word  (hold_word),
        .sout  (sout)
    );

    // driver enable is combinational in en and pwrdn
    assign sout_oe = en & run_ok;

endmodule

// File: rtl/wser_chk.sv
module wser_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwrdn,
    input logic              load,
    input logic              sync_sel,
    input logic              burst_act,
    input logic              locked,
    input logic              cap,
    input logic [DATA_W-1:0] hold,
    input logic              sout
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CW      = $clog2(FRAME_W + 2);
    localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);
    localparam logic [CW-1:0] HALF = CW'(FRAME_W / 2);
    localparam logic [CW-1:0] CMAX = CW'(FRAME_W + 1);

    logic [CW-1:0] cnt_q;
    logic          started_q;
    logic          syncf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
            syncf_q   <= 1'b0;
        end else if (load) begin
            cnt_q     <= '0;
            started_q <= 1'b1;
            syncf_q   <= sync_sel;
        end else if (pwrdn) begin
            started_q <= 1'b0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_START_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sync_sel) |=> sout);  // R1
    AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !syncf_q && cnt_q == LAST) |-> !sout);  // R1
    AST_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && syncf_q && cnt_q < HALF) |-> sout);  // R5
    AST_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && syncf_q && cnt_q >= HALF && cnt_q <= LAST) |-> !sout);  // R5
    AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && burst_act) |-> sync_sel);  // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !pwrdn) |=> $stable(hold));  // R4
    AST_PD_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !locked);  // R12
    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!pwrdn));  // R10
    AST_NO_LOAD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> locked);  // R10

endmodule

bind wser_top wser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn     (pwrdn),
    .load      (frame_load),
    .sync_sel  (frame_is_sync),
    .burst_act (burst_act),
    .locked    (locked),
    .cap       (cap_strobe),
    .hold      (hold_word),
    .sout      (sout)
);

// File: tb/tb_wser_top.sv
module tb_wser_top;

    localparam int DW    = 10;
    localparam int LOCKN = 4;
    localparam int QUALN = 6;
    localparam int MINN  = 10;
    localparam logic [11:0] SYNC_FRAME = 12'h03F;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ref_clk;
    logic          edge_sel;
    logic [DW-1:0] din;
    logic          sync_req;
    logic          en;
    logic          pwrdn;
    logic          sout;
    logic          sout_oe;

    always #5 clk = ~clk;

    wser_top #(
        .DATA_W      (DW),
        .LOCK_FRAMES (LOCKN),
        .SYNC_QUAL   (QUALN),
        .SYNC_MIN    (MINN)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .edge_sel (edge_sel),
        .din      (din),
        .sync_req (sync_req),
        .en       (en),
        .pwrdn    (pwrdn),
        .sout     (sout),
        .sout_oe  (sout_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // frame-level reference state
    bit            m_locked = 0;
    int            m_lockcnt = 0;
    logic [DW-1:0] m_hold = '0;
    int            m_qual = 0;
    int            m_burst = 0;
    bit            exp_valid = 0;
    logic [11:0]   exp_frame = '0;
    logic [11:0]   coll = '0;
    string         exp_tag = "R1";
    string         cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [11:0] data_frame(input logic [DW-1:0] d);
        return {1'b0, d, 1'b1};
    endfunction

    task automatic model_rise(input logic [DW-1:0] d_r, input bit sreq, input bit sel, input bit pd);
        int qn;
        if (pd) begin
            m_locked = 0; m_lockcnt = 0; m_hold = '0; m_qual = 0; m_burst = 0;
            exp_valid = 0;
        end else if (!m_locked) begin
            m_lockcnt++;
            if (m_lockcnt == LOCKN) begin
                m_locked = 1; m_lockcnt = 0;
            end
            exp_valid = 0;
        end else begin
            qn = sreq ? ((m_qual < QUALN) ? m_qual + 1 : QUALN) : 0;
            if (m_burst > 0) begin
                exp_frame = SYNC_FRAME; m_burst--;
            end else if (qn == QUALN) begin
                exp_frame = SYNC_FRAME; m_burst = MINN - 1;
            end else begin
                exp_frame = data_frame(m_hold);
            end
            m_qual    = qn;
            exp_valid = 1;
            exp_tag   = cur_tag;
            if (sel) m_hold = d_r;
        end
    endtask

    task automatic model_fall(input logic [DW-1:0] d_f, input bit sel, input bit pd);
        if (m_locked && !pd && !sel) m_hold = d_f;
    endtask

    // one word period: sample previous frame bits, drive this period's inputs
    task automatic do_frame(input logic [DW-1:0] d_r, input logic [DW-1:0] d_f,
                            input bit sreq, input bit sreq_mid, input bit sel,
                            input bit en_v, input bit en_mid, input bit pd);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (j == 0) begin
                coll[11] = sout;
                if (exp_valid) chk(coll == exp_frame, exp_tag, 32'(coll), 32'(exp_frame));
                chk(sout_oe == (en & ~pwrdn & m_locked), m_locked ? "R9" : "R10",
                    32'(sout_oe), 32'(en & ~pwrdn & m_locked));
                ref_clk  = 1'b1;
                edge_sel = sel;
                din      = d_r;
                sync_req = sreq;
                en       = en_v;
                pwrdn    = pd;
                model_rise(d_r, sreq, sel, pd);
            end else begin
                coll[j-1] = sout;
                ref_clk   = (j < 6);
                if (j == 3) begin
                    en = en_mid;
                    #1;
                    chk(sout_oe == (en_mid & ~pd & m_locked), "R9",
                        32'(sout_oe), 32'(en_mid & ~pd & m_locked));
                end
                if (j == 6) begin
                    if (pd) chk(sout == 1'b0, "R12", 32'(sout), 32'd0);
                    din      = d_f;
                    sync_req = sreq_mid;
                    model_fall(d_f, sel, pd);
                end
            end
        end
    endtask

    task automatic data_frames(input int n, input bit sel);
        for (int k = 0; k < n; k++) begin
            do_frame(DW'($urandom), DW'($urandom), 1'b0, 1'b0, sel, 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        int sync_run;
        bit sel_r;
        bit sr;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; ref_clk = 1'b0; edge_sel = 1'b1; din = '0;
        sync_req = 1'b0; en = 1'b1; pwrdn = 1'b0;
        repeat (3) @(negedge clk);
        chk(sout == 1'b0, "R10", 32'(sout), 32'd0);
        chk(sout_oe == 1'b0, "R10", 32'(sout_oe), 32'd0);
        rst_n = 1'b1;

        // lock wait: no output enable for LOCKN word periods
        cur_tag = "R10";
        for (int k = 0; k < LOCKN; k++)
            do_frame(10'h3A5, 10'h05A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        // first frame after lock carries zero data
        cur_tag = "R11";
        do_frame(10'h001, 10'h3FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        // directed words on rising-edge capture, LSB first
        cur_tag = "R2";
        do_frame(10'h200, 10'h0F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        do_frame(10'h3FF, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        do_frame(10'h155, 10'h2AA, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        cur_tag = "R1";
        do_frame(10'h000, 10'h3FF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        do_frame(10'h2AA, 10'h155, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        // falling-edge capture; rising-edge words must not appear
        cur_tag = "R3";
        do_frame(10'h111, 10'h222, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        do_frame(10'h333, 10'h0CC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        cur_tag = "R4";
        do_frame(10'h3C3, 10'h03C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        do_frame(10'h0AA, 10'h355, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        data_frames(2, 1'b1);

        // too short a request run: data continues
        cur_tag = "R6";
        for (int k = 0; k < QUALN - 1; k++)
            do_frame(DW'($urandom), DW'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        data_frames(2, 1'b1);

        // exact qualifying run, then burst with sync_req toggling
        for (int k = 0; k < QUALN; k++)
            do_frame(DW'($urandom), DW'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        cur_tag = "R7";
        for (int k = 0; k < MINN + 3; k++)
            do_frame(DW'($urandom), DW'($urandom), 1'(k % 3 == 1), 1'(k % 2), 1'b1, 1'b1, 1'b1, 1'b0);

        // sustained request beyond minimum burst
        cur_tag = "R8";
        for (int k = 0; k < QUALN + MINN + 6; k++)
            do_frame(DW'($urandom), DW'($urandom), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        data_frames(3, 1'b1);

        // mid-frame request changes never alter the frame type
        cur_tag = "R5";
        for (int k = 0; k < 4; k++)
            do_frame(DW'($urandom), DW'($urandom), 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

        // enable toggled asynchronously while frames keep running
        cur_tag = "R9";
        do_frame(10'h123, 10'h321, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_frame(10'h0F0, 10'h00F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        do_frame(10'h3E1, 10'h1E3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        data_frames(2, 1'b1);

        // power-down clears state; relock, then zero data first
        cur_tag = "R12";
        do_frame(10'h2F1, 10'h1F2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        do_frame(10'h2F1, 10'h1F2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < LOCKN; k++)
            do_frame(10'h3F3, 10'h0C0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        do_frame(10'h18F, 10'h0C0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        cur_tag = "R2";
        data_frames(2, 1'b1);

        // constrained random traffic
        sync_run = 0;
        sel_r    = 1'b1;
        for (int k = 0; k < 300; k++) begin
            if (k % 16 == 0) sel_r = 1'($urandom);
            if (sync_run > 0) begin
                sr = 1'b1; sync_run--;
            end else begin
                sr = 1'b0;
                if ($urandom % 30 == 0) sync_run = int'($urandom % 12);
            end
            cur_tag = sr ? "R5" : "R1";
            do_frame(DW'($urandom), DW'($urandom), sr, 1'($urandom), sel_r,
                     ($urandom % 8) != 0, ($urandom % 8) != 0, 1'b0);
        end
        // flush the last frame
        do_frame(10'h000, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        finish_run();
    end

endmodule